// File: doc/BRIEF.md
# Banked Memory Pattern Self-Test Controller

This controller is a built-in self-test engine for a large byte-wide memory that is reached only through a small bank window. A memory location can be used only after a bank-select write, so the controller writes the bank number to the select register before it touches each bank. One run has three passes. Each pass writes a pattern to every byte of every bank and then reads all of it back and compares. No read starts until the whole memory has been written, so every byte sits untouched for a long interval before it is checked.

The first two passes write a checkerboard, the second with its phase inverted. The third pass writes a per-bank signature in which the bank number is mixed into each byte. It reads the banks back in a pseudo-random order, so banks that alias onto each other or answer to the wrong select value show up as mismatches. The controller keeps the first failing location and a saturating error count. It always finishes the full run and then reports pass or fail on a held done flag.

Top module: `banked_mem_bist`

## Requirements
- R1: A run has six phases in a fixed order: write pass 0, read pass 0, write pass 1, read pass 1, write pass 2, read pass 2. Within a phase every data access is a write or every data access is a read (`mem_we` high or low), and each phase covers all offsets of all banks.
- R2: Each bank is entered with a bank-select access (`mem_sel`=1, `mem_we`=1, `mem_wdata` = bank number, zero-extended). This is followed by data accesses (`mem_sel`=0) to offsets 0, 1, ... up to the last offset, in ascending order.
- R3: In pass 0 a byte at an even offset is written as 0x55 and a byte at an odd offset is written as 0xAA. Pass 1 writes the inverse: 0xAA at even offsets and 0x55 at odd offsets.
- R4: In pass 2 each byte is written as (offset mod 256) XOR bank number.
- R5: All write phases and the first two read phases visit the banks in ascending order. The pass-2 read visits bank 0 first and then the LFSR states, starting from the seed that `lfsr_seed` held at start (a seed of 0 is replaced by 1). The LFSR shifts toward the MSB, and its new LSB is the XOR of the tap bits: bits 2,1 for 3 bank bits and bits 5,4 for 6 bank bits.
- R6: A request holds `mem_req`, `mem_addr`, `mem_wdata`, `mem_we` and `mem_sel` unchanged until `mem_ack` is sampled high. The access completes in the cycle where both are high, and read data is taken in that cycle.
- R7: When a read byte differs from its expected value, the controller latches the bank, offset, expected byte and read byte of the first mismatch of the run. Later mismatches do not change them.
- R8: Each mismatch adds one to `err_count`. The count stops at its all-ones value and never wraps.
- R9: At the end of the run `done` rises and stays high, and `mem_req` stays low. `pass_ok` is high only if `err_count` is 0. A start pulse while `busy` is ignored. A start pulse while idle or done clears the count and the latched error and begins a new run.
- R10: After reset `busy`, `done`, `pass_ok` and `mem_req` are low and `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| lfsr_seed | input | BANK_BITS | Seed for the pass-2 read bank order, sampled at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| pass_ok | output | 1 | Run finished with no mismatch |
| err_count | output | ERR_W | Saturating mismatch count |
| err_bank | output | BANK_BITS | Bank of the first mismatch |
| err_offset | output | OFF_BITS | Offset of the first mismatch |
| err_expected | output | 8 | Expected byte of the first mismatch |
| err_actual | output | 8 | Byte read at the first mismatch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_sel | output | 1 | 1 = bank-select register access, 0 = data access |
| mem_addr | output | OFF_BITS | Offset inside the bank window |
| mem_wdata | output | 8 | Write data or bank number |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes in this cycle |

## Verification
The last comparison of a run and the rise of `done` happen on the same acknowledged read, so a fault on the final location can be lost if the two interfere. The bench places a fault on the last bank of the shuffled order at its last offset. It then requires that the mismatch is counted and that `pass_ok` stays low. A memory model with random acknowledge latency also runs a bank-alias fault that only the signature pass can see, a stuck-at-zero read that drives the counter into saturation, and a start pulse issued in the middle of a run.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_ACC, ST_DONE} bist_state_t;

  // Expected byte for a pass (0,1 checkerboard, 2 signature)
  function automatic logic [7:0] exp_byte(input logic [1:0] pass,
                                          input logic [7:0] bank,
                                          input logic [31:0] off);
    logic [7:0] r;
    case (pass)
      2'd0:    r = off[0] ? 8'hAA : 8'h55;
      2'd1:    r = off[0] ? 8'h55 : 8'hAA;
      default: r = off[7:0] ^ bank;
    endcase
    return r;
  endfunction

  // Tap mask of a maximal-length shift register, widths 2..8
  function automatic logic [7:0] lfsr_taps(input int w);
    logic [7:0] m;
    case (w)
      2:       m = 8'b0000_0011;
      3:       m = 8'b0000_0110;
      4:       m = 8'b0000_1100;
      5:       m = 8'b0001_0100;
      6:       m = 8'b0011_0000;
      7:       m = 8'b0110_0000;
      default: m = 8'b1011_1000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bist_bank_order.sv
module bist_bank_order import bist_pkg::*; #(
  parameter int BANK_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [BANK_BITS-1:0] seed,
  input  logic                 adv,
  input  logic                 shuffle,
  input  logic [BANK_BITS-1:0] step,
  output logic [BANK_BITS-1:0] bank
);
  localparam logic [7:0] TAPS8 = lfsr_taps(BANK_BITS);
  localparam logic [BANK_BITS-1:0] TAPS = TAPS8[BANK_BITS-1:0];
  localparam logic [BANK_BITS-1:0] ONE = BANK_BITS'(1);

  logic [BANK_BITS-1:0] lfsr_q;
  logic [BANK_BITS-1:0] lfsr_nxt;
  logic                 fb;

  assign fb       = ^(lfsr_q & TAPS);
  assign lfsr_nxt = {lfsr_q[BANK_BITS-2:0], fb};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr_q <= ONE;
    else if (load) lfsr_q <= (seed == '0) ? ONE : seed;
    else if (adv)  lfsr_q <= lfsr_nxt;
  end

  generate
    if (BANK_BITS > 1) begin : g_order
      assign bank = !shuffle ? step : ((step == '0) ? '0 : lfsr_q);
    end else begin : g_single
      assign bank = step;
    end
  endgenerate

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R5

endmodule

// File: rtl/bist_err_log.sv
module bist_err_log #(
  parameter int ERR_W     = 16,
  parameter int BANK_BITS = 6,
  parameter int OFF_BITS  = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 cmp_valid,
  input  logic [BANK_BITS-1:0] bank,
  input  logic [OFF_BITS-1:0]  off,
  input  logic [7:0]           exp_b,
  input  logic [7:0]           act_b,
  output logic [ERR_W-1:0]     err_count,
  output logic [BANK_BITS-1:0] first_bank,
  output logic [OFF_BITS-1:0]  first_off,
  output logic [7:0]           first_exp,
  output logic [7:0]           first_act
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic mismatch;
  logic seen_q;

  assign mismatch = cmp_valid && (exp_b != act_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count <= '0; seen_q <= 1'b0;
      first_bank <= '0; first_off <= '0; first_exp <= '0; first_act <= '0;
    end else if (clear) begin
      err_count <= '0; seen_q <= 1'b0;
      first_bank <= '0; first_off <= '0; first_exp <= '0; first_act <= '0;
    end else if (mismatch) begin
      if (err_count != ERR_MAX) err_count <= err_count + 1'b1;
      if (!seen_q) begin
        seen_q     <= 1'b1;
        first_bank <= bank;
        first_off  <= off;
        first_exp  <= exp_b;
        first_act  <= act_b;
      end
    end
  end

  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == ERR_MAX && !clear) |=> err_count == ERR_MAX); // R8
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ({1'b0, err_count} == {1'b0, $past(err_count)} ||
                {1'b0, err_count} == {1'b0, $past(err_count)} + 1'b1)); // R8
  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !clear) |=> ($stable(first_bank) && $stable(first_off) &&
                            $stable(first_exp) && $stable(first_act))); // R7

endmodule

// File: rtl/banked_mem_bist.sv
module banked_mem_bist import bist_pkg::*; #(
  parameter int BANK_BITS = 6,
  parameter int OFF_BITS  = 14,
  parameter int ERR_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BANK_BITS-1:0] lfsr_seed,
  output logic                 busy,
  output logic                 done,
  output logic                 pass_ok,
  output logic [ERR_W-1:0]     err_count,
  output logic [BANK_BITS-1:0] err_bank,
  output logic [OFF_BITS-1:0]  err_offset,
  output logic [7:0]           err_expected,
  output logic [7:0]           err_actual,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 mem_sel,
  output logic [OFF_BITS-1:0]  mem_addr,
  output logic [7:0]           mem_wdata,
  input  logic [7:0]           mem_rdata,
  input  logic                 mem_ack
);
  localparam logic [2:0]           LAST_PH  = 3'd5;
  localparam logic [BANK_BITS-1:0] BANK_MAX = {BANK_BITS{1'b1}};
  localparam logic [OFF_BITS-1:0]  OFF_MAX  = {OFF_BITS{1'b1}};

  bist_state_t          state_q;
  logic [2:0]           ph_q;
  logic [BANK_BITS-1:0] step_q;
  logic [OFF_BITS-1:0]  off_q;
  logic [BANK_BITS-1:0] cur_bank;
  logic [7:0]           pat_byte;

  // named internal events
  logic start_go, xfer, sel_xfer, data_xfer, off_last, bank_last;
  logic bank_end, phase_end, run_end, rd_phase, shuffle, cmp_valid, lfsr_adv;

  assign start_go  = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign xfer      = mem_req && mem_ack;
  assign sel_xfer  = xfer && (state_q == ST_SEL);
  assign data_xfer = xfer && (state_q == ST_ACC);
  assign off_last  = (off_q == OFF_MAX);
  assign bank_last = (step_q == BANK_MAX);
  assign bank_end  = data_xfer && off_last;
  assign phase_end = bank_end && bank_last;
  assign run_end   = phase_end && (ph_q == LAST_PH);
  assign rd_phase  = ph_q[0];
  assign shuffle   = (ph_q == LAST_PH);
  assign cmp_valid = data_xfer && rd_phase;
  assign lfsr_adv  = bank_end && shuffle && (step_q != '0);

  bist_bank_order #(.BANK_BITS(BANK_BITS)) u_order (
    .clk(clk), .rst_n(rst_n), .load(start_go), .seed(lfsr_seed),
    .adv(lfsr_adv), .shuffle(shuffle), .step(step_q), .bank(cur_bank)
  );

  assign pat_byte = exp_byte(ph_q[2:1], 8'(cur_bank), 32'(off_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      step_q  <= '0;
      off_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (start_go) begin
          state_q <= ST_SEL;
          ph_q    <= '0;
          step_q  <= '0;
          off_q   <= '0;
        end
        ST_SEL: if (sel_xfer) state_q <= ST_ACC;
        ST_ACC: if (data_xfer) begin
          off_q <= off_q + 1'b1;
          if (off_last) begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_SEL;
            if (bank_last) begin
              if (run_end) state_q <= ST_DONE;
              else         ph_q    <= ph_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == ST_SEL) || (state_q == ST_ACC);
  assign done      = (state_q == ST_DONE);
  assign mem_req   = busy;
  assign mem_sel   = (state_q == ST_SEL);
  assign mem_we    = mem_sel || !rd_phase;
  assign mem_addr  = mem_sel ? '0 : off_q;
  assign mem_wdata = mem_sel ? 8'(cur_bank) : (rd_phase ? 8'h00 : pat_byte);

  bist_err_log #(.ERR_W(ERR_W), .BANK_BITS(BANK_BITS), .OFF_BITS(OFF_BITS)) u_log (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .cmp_valid(cmp_valid),
    .bank(cur_bank), .off(off_q), .exp_b(pat_byte), .act_b(mem_rdata),
    .err_count(err_count), .first_bank(err_bank), .first_off(err_offset),
    .first_exp(err_expected), .first_act(err_actual)
  );

  assign pass_ok = done && (err_count == '0);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) &&
                               $stable(mem_we) && $stable(mem_sel))); // R6
  AST_SEL_THEN_OFF0: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mem_sel) |=> (mem_req && !mem_sel && mem_addr == '0)); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R9
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R9

endmodule

// File: tb/banked_mem_bist_bench.sv
module banked_mem_bist_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BB = 3;
  localparam int OB = 5;
  localparam int EW = 8;
  localparam int NB = 8;
  localparam int NO = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [BB-1:0] lfsr_seed = '0;
  logic busy, done, pass_ok;
  logic [EW-1:0] err_count;
  logic [BB-1:0] err_bank;
  logic [OB-1:0] err_offset;
  logic [7:0] err_expected, err_actual;
  logic mem_req, mem_we, mem_sel;
  logic [OB-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic mem_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_mem_bist #(.BANK_BITS(BB), .OFF_BITS(OB), .ERR_W(EW)) u_banked_mem_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .lfsr_seed(lfsr_seed),
    .busy(busy), .done(done), .pass_ok(pass_ok), .err_count(err_count),
    .err_bank(err_bank), .err_offset(err_offset), .err_expected(err_expected),
    .err_actual(err_actual), .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench view of the bank visit order
  function automatic int step3(input int s);
    return ((s * 2) % 8) + (((s / 4) + (s / 2)) % 2);
  endfunction
  int ord [NB];
  task automatic build_order(input int seed);
    int s = (seed == 0) ? 1 : seed;
    ord[0] = 0;
    for (int i = 1; i < NB; i++) begin ord[i] = s; s = step3(s); end
  endtask

  function automatic int pattern(input int pass, input int bank, input int off);
    int lin = bank * NO + off;
    if (pass == 0) return (lin % 2 == 1) ? 8'hAA : 8'h55;
    if (pass == 1) return (lin % 2 == 1) ? 8'h55 : 8'hAA;
    return (off % 256) ^ bank;
  endfunction

  // memory model and sequence monitor
  logic [7:0] mem_arr [NB*NO];
  int bank_reg = 0, lat = 0;
  int fmode = 0, fb = 0, fo = 0, fmask = 0;
  int m_ph = 0, m_step = 0, m_off = 0;
  bit m_sel = 1;

  task automatic do_access();
    int eb, pb, d;
    eb = (m_ph == 5) ? ord[m_step] : m_step;
    if (m_ph > 5) chk(1'b0, "R9 access after run end", m_ph, 6);
    if (mem_sel) begin
      chk(m_sel && mem_we, "R2 unexpected bank select", int'(mem_sel), 0);
      chk(int'(mem_wdata) == eb, (m_ph == 5) ? "R5 shuffled bank order" : "R5 ascending bank order",
          mem_wdata, eb);
      bank_reg = mem_wdata % NB;
      m_sel = 0;
    end else begin
      chk(!m_sel && int'(mem_addr) == m_off, "R2 data offset sequence", mem_addr, m_off);
      chk(mem_we == (m_ph % 2 == 0), "R1 phase direction", mem_we, (m_ph % 2 == 0));
      pb = (fmode == 2) ? (bank_reg / 2) * 2 : bank_reg;
      if (mem_we) begin
        chk(int'(mem_wdata) == pattern(m_ph / 2, eb, m_off),
            (m_ph >= 4) ? "R4 signature byte" : "R3 checkerboard byte",
            mem_wdata, pattern(m_ph / 2, eb, m_off));
        mem_arr[pb * NO + int'(mem_addr)] = mem_wdata;
      end else begin
        d = mem_arr[pb * NO + int'(mem_addr)];
        if (fmode == 1 && bank_reg == fb && int'(mem_addr) == fo) d = d ^ fmask;
        if (fmode == 3) d = 0;
        mem_rdata = 8'(d);
      end
      m_off++;
      if (m_off == NO) begin
        m_off = 0; m_sel = 1; m_step++;
        if (m_step == NB) begin m_step = 0; m_ph++; end
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; lat = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; lat = $urandom % 3;
    end else if (mem_req) begin
      if (lat != 0) lat--;
      else begin do_access(); mem_ack = 1'b1; end
    end
  end

  task automatic finish_now();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run(input int seed, input int mode, input bit restart_mid);
    build_order(seed);
    fmode = mode;
    m_ph = 0; m_step = 0; m_off = 0; m_sel = 1;
    @(negedge clk); lfsr_seed = BB'(seed); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err_count == 0 && !done && busy, "R9 start clears and begins", err_count, 0);
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (restart_mid && c == 700) begin lfsr_seed = BB'(seed + 1); start = 1'b1; end
      else start = 1'b0;
      if (done) break;
    end
    if (!done) begin
      chk(1'b0, "R9 watchdog expired", 0, 1);
      finish_now();
    end
    repeat (3) @(negedge clk);
    chk(done && !mem_req && !busy, "R9 done held and quiet", done, 1);
    chk(m_ph == 6, "R1 all six phases completed", m_ph, 6);
  endtask

  initial begin
    int lb;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass_ok && !mem_req && err_count == 0, "R10 reset state", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_req, "R10 idle after reset release", mem_req, 0);

    // clean run with a random nonzero seed
    run(1 + ($urandom % 7), 0, 1'b0);
    chk(pass_ok && err_count == 0, "R9 clean run passes", err_count, 0);

    // seed of zero replaced by one; start in mid-run ignored
    run(0, 0, 1'b1);
    chk(pass_ok && err_count == 0, "R9 start while busy ignored", err_count, 0);

    // random single flipped byte
    fb = $urandom % NB; fo = $urandom % NO; fmask = 1 + ($urandom % 255);
    run(1 + ($urandom % 7), 1, 1'b0);
    chk(err_count == 3 && !pass_ok, "R8 one count per mismatch", err_count, 3);
    chk(err_bank == BB'(fb) && err_offset == OB'(fo), "R7 first mismatch location",
        {err_bank, err_offset}, fb * NO + fo);
    chk(err_expected == 8'(pattern(0, fb, fo)) && err_actual == 8'(pattern(0, fb, fo) ^ fmask),
        "R7 first mismatch data", err_actual, pattern(0, fb, fo) ^ fmask);

    // fault on the final location read in the run
    build_order(5); lb = ord[NB-1];
    fb = lb; fo = NO - 1; fmask = 8'h80;
    run(5, 1, 1'b0);
    chk(err_count == 3 && !pass_ok, "R9 last compare counted at done", err_count, 3);
    chk(err_bank == BB'(lb) && err_offset == OB'(NO - 1), "R7 last location latched",
        err_bank, lb);

    // bank alias: bank bit 0 ignored by the memory
    run(3, 2, 1'b0);
    chk(err_count == 128 && !pass_ok, "R4 alias seen only by signature", err_count, 128);
    chk(err_bank == 0 && err_offset == 0 && err_expected == 8'h00 && err_actual == 8'h01,
        "R7 alias first mismatch", err_actual, 8'h01);

    // all reads return zero: counter saturates
    run(6, 3, 1'b0);
    chk(err_count == 8'hFF, "R8 counter saturates", err_count, 8'hFF);
    chk(err_expected == 8'h55 && err_actual == 8'h00 && err_bank == 0 && err_offset == 0,
        "R7 first of many latched", err_expected, 8'h55);

    // restart after failure clears
    run(2, 0, 1'b0);
    chk(pass_ok && err_count == 0 && err_expected == 0, "R9 new start clears error", err_count, 0);

    finish_now();
  end
endmodule